// File: doc/BRIEF.md
# Four-Channel Interrupt Cause Aggregator

This block collects interrupt causes from the channels of a multi-channel Ethernet controller and merges them into one interrupt line. Each channel's MAC and DMA logic sends single-cycle event pulses. The aggregator latches each pulse into a sticky bit of that channel's cause register. It also runs five 8-bit event counters per channel, for collisions, runts, missed frames, FCS errors and code errors. When a counter wraps, it sets an overflow cause bit, and the host counts that bit as 256 events.

The host reaches everything through a simple register port, with a read strobe, a write strobe and an address. It first reads one global word, in which every channel owns a 4-bit summary nibble, to find out which channel needs service. It then reads that channel's cause register, and the read clears the register. Three mask registers per channel (receive, transmit and MAC) keep chosen causes out of the summary and out of the interrupt. A masked cause is still recorded in the cause register.

Top module: `chan_irq_aggregator`

## Requirements
- R1: While reset is asserted and immediately after it, every cause register, mask register and counter is zero, `irq` is low and `host_rdata` is zero.
- R2: A pulse on an event input sets its cause bit at the next clock edge. The cause bit layout is: bits 0-6 are the MAC errors `ev_mac_err[7c+0..6]`, bits 7-9 are the DMA errors `ev_dma_err[3c+0..2]`, bits 10-14 are the counter overflows (collision, runt, missed, FCS, code, in `ev_cnt_inc` order), bit 15 is transmit-done and bit 16 is receive-done. A set bit stays set until the register is read.
- R3: A read of a channel's cause register (offset 0) returns its contents and then clears the register. An event that arrives in the same cycle as that read is kept.
- R4: Each counter is 8 bits wide. Its 256th increment sets its overflow bit and takes the counter back to zero, so 255 increments leave the overflow bit clear.
- R5: A set mask bit keeps its cause out of the summary nibble and out of `irq`, but the cause is still latched. The mask registers sit at channel offsets 1, 2 and 3. Receive mask (offset 1): bit 0 masks receive-done. Transmit mask (offset 2): bits 0-2 mask the DMA errors and bit 3 masks transmit-done. MAC mask (offset 3): bits 0-6 mask the MAC errors and bits 7-11 mask the counter overflows. All masks reset to zero, which means unmasked.
- R6: MAC mask bit 7 masks the collision-counter overflow and nothing else.
- R7: The global status word is read at address 16. Channel c's nibble is at bits [4c+3:4c]. Within a nibble, bit 0 is any unmasked error, bit 1 is unmasked transmit-done, bit 2 is unmasked receive-done and bit 3 is any unmasked counter overflow. A nibble of zero means the channel has no cause pending.
- R8: `irq` is high exactly when at least one channel nibble is nonzero.
- R9: Writes to cause-register addresses and to the global address have no effect. A mask read returns the stored field, zero-extended, so bits beyond the field width are dropped.
- R10: Channel c's registers are at address 4c plus the offset. Read data appears on `host_rdata` in the cycle after `host_rd`, and `host_rdata` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_mac_err | input | 28 | MAC error pulses, 7 per channel |
| ev_dma_err | input | 12 | DMA error pulses, 3 per channel |
| ev_cnt_inc | input | 20 | Counter increment pulses, 5 per channel |
| ev_tx_done | input | 4 | Transmit-done pulse per channel |
| ev_rx_done | input | 4 | Receive-done pulse per channel |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 5 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sends an event pulse in the same cycle as the clearing read of that channel. A design that applies the clear after the set would lose the event, and `irq` would fall with work still pending. The counters are driven to 255 and then 256 increments twice over. This catches an overflow that fires one count early, and a counter that does not restart from zero, which would move the second overflow. The collision overflow is masked alone while an FCS overflow on the same channel must still raise `irq`. A mask decoded at the wrong bit would either silence both or silence neither. Writes aimed at cause and global addresses show whether the decode lets them reach the mask registers.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;

    localparam int NUM_MAC_ERR = 7;
    localparam int NUM_DMA_ERR = 3;
    localparam int NUM_CNT     = 5;
    localparam int NIB_W       = 4;

    localparam int OVF_LO  = NUM_MAC_ERR + NUM_DMA_ERR;
    localparam int TXD_BIT = OVF_LO + NUM_CNT;
    localparam int RXD_BIT = TXD_BIT + 1;
    localparam int STAT_W  = RXD_BIT + 1;

    localparam int RX_MASK_W  = 1;
    localparam int TX_MASK_W  = NUM_DMA_ERR + 1;
    localparam int MAC_MASK_W = NUM_MAC_ERR + NUM_CNT;

    localparam int NIB_ERR = 0;
    localparam int NIB_TX  = 1;
    localparam int NIB_RX  = 2;
    localparam int NIB_OVF = 3;

    typedef enum logic [1:0] {
        REG_CAUSE = 2'd0,
        REG_RXM   = 2'd1,
        REG_TXM   = 2'd2,
        REG_MACM  = 2'd3
    } reg_sel_e;

    // same bit order as the cause register
    typedef struct packed {
        logic                   rx_done;
        logic                   tx_done;
        logic [NUM_CNT-1:0]     cnt_inc;
        logic [NUM_DMA_ERR-1:0] dma_err;
        logic [NUM_MAC_ERR-1:0] mac_err;
    } chan_ev_t;

    // expand the three mask fields onto cause-bit positions
    function automatic logic [STAT_W-1:0] mask_vec(
        input logic [RX_MASK_W-1:0]  rxm,
        input logic [TX_MASK_W-1:0]  txm,
        input logic [MAC_MASK_W-1:0] macm
    );
        return {rxm[0], txm[TX_MASK_W-1],
                macm[MAC_MASK_W-1:NUM_MAC_ERR],
                txm[NUM_DMA_ERR-1:0],
                macm[NUM_MAC_ERR-1:0]};
    endfunction

    function automatic logic [NIB_W-1:0] summarize(input logic [STAT_W-1:0] unm);
        logic [NIB_W-1:0] n;
        n[NIB_ERR] = |unm[OVF_LO-1:0];
        n[NIB_TX]  = unm[TXD_BIT];
        n[NIB_RX]  = unm[RXD_BIT];
        n[NIB_OVF] = |unm[TXD_BIT-1:OVF_LO];
        return n;
    endfunction

endpackage

// File: rtl/evt_wrap_counter.sv
module evt_wrap_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // wrap back to zero is what restarts the count after an overflow
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign wrap = inc && (cnt_q == CNT_MAX);
endmodule

// File: rtl/evt_chan_cause.sv
module evt_chan_cause
    import evt_agg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  chan_ev_t              ev,
    input  logic                  clr,
    input  logic                  wr_rxm,
    input  logic                  wr_txm,
    input  logic                  wr_macm,
    input  logic [MAC_MASK_W-1:0] wdata,
    output logic [STAT_W-1:0]     cause,
    output logic [RX_MASK_W-1:0]  rxm,
    output logic [TX_MASK_W-1:0]  txm,
    output logic [MAC_MASK_W-1:0] macm,
    output logic [NIB_W-1:0]      nib
);
    logic [NUM_CNT-1:0] wrap;
    logic [STAT_W-1:0]  set_vec;
    logic [STAT_W-1:0]  cause_q;
    logic [RX_MASK_W-1:0]  rxm_q;
    logic [TX_MASK_W-1:0]  txm_q;
    logic [MAC_MASK_W-1:0] macm_q;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        evt_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .inc  (ev.cnt_inc[i]),
            .wrap (wrap[i])
        );
    end

    assign set_vec = {ev.rx_done, ev.tx_done, wrap, ev.dma_err, ev.mac_err};

    // clear-on-read first, then merge this cycle's events so none is lost
    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else
            cause_q <= (clr ? '0 : cause_q) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxm_q  <= '0;
            txm_q  <= '0;
            macm_q <= '0;
        end else begin
            if (wr_rxm)  rxm_q  <= wdata[RX_MASK_W-1:0];
            if (wr_txm)  txm_q  <= wdata[TX_MASK_W-1:0];
            if (wr_macm) macm_q <= wdata;
        end
    end

    assign cause = cause_q;
    assign rxm   = rxm_q;
    assign txm   = txm_q;
    assign macm  = macm_q;
    assign nib   = summarize(cause_q & ~mask_vec(rxm_q, txm_q, macm_q));
endmodule

// File: rtl/evt_host_port.sv
module evt_host_port
    import evt_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 5
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                host_rd,
    input  logic                                host_wr,
    input  logic [ADDR_W-1:0]                   host_addr,
    input  logic [NUM_CH-1:0][STAT_W-1:0]       cause_all,
    input  logic [NUM_CH-1:0][RX_MASK_W-1:0]    rxm_all,
    input  logic [NUM_CH-1:0][TX_MASK_W-1:0]    txm_all,
    input  logic [NUM_CH-1:0][MAC_MASK_W-1:0]   macm_all,
    input  logic [NUM_CH*NIB_W-1:0]             glob,
    output logic [DATA_W-1:0]                   host_rdata,
    output logic [NUM_CH-1:0]                   clr_all,
    output logic [NUM_CH-1:0]                   wr_rxm,
    output logic [NUM_CH-1:0]                   wr_txm,
    output logic [NUM_CH-1:0]                   wr_macm
);
    localparam logic [CH_W:0] NUM_CH_V = (CH_W+1)'(NUM_CH);

    logic            is_glob;
    logic [CH_W-1:0] sel_ch;
    reg_sel_e        sel_reg;
    logic            ch_ok;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign is_glob = host_addr[ADDR_W-1];
    assign sel_ch  = host_addr[CH_W+1:2];
    assign sel_reg = reg_sel_e'(host_addr[1:0]);
    assign ch_ok   = !is_glob && ({1'b0, sel_ch} < NUM_CH_V);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        logic hit;
        assign hit        = ch_ok && (sel_ch == CH_W'(c));
        assign clr_all[c] = host_rd && hit && (sel_reg == REG_CAUSE);
        assign wr_rxm[c]  = host_wr && hit && (sel_reg == REG_RXM);
        assign wr_txm[c]  = host_wr && hit && (sel_reg == REG_TXM);
        assign wr_macm[c] = host_wr && hit && (sel_reg == REG_MACM);
    end

    always_comb begin
        rd_mux = '0;
        if (is_glob) begin
            rd_mux = DATA_W'(glob);
        end else if (ch_ok) begin
            case (sel_reg)
                REG_CAUSE: rd_mux = DATA_W'(cause_all[sel_ch]);
                REG_RXM:   rd_mux = DATA_W'(rxm_all[sel_ch]);
                REG_TXM:   rd_mux = DATA_W'(txm_all[sel_ch]);
                REG_MACM:  rd_mux = DATA_W'(macm_all[sel_ch]);
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else
            rdata_q <= host_rd ? rd_mux : '0;
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/chan_irq_aggregator.sv
module chan_irq_aggregator
    import evt_agg_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int CNT_W  = 8,
    parameter  int DATA_W = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH*NUM_MAC_ERR-1:0] ev_mac_err,
    input  logic [NUM_CH*NUM_DMA_ERR-1:0] ev_dma_err,
    input  logic [NUM_CH*NUM_CNT-1:0]     ev_cnt_inc,
    input  logic [NUM_CH-1:0]             ev_tx_done,
    input  logic [NUM_CH-1:0]             ev_rx_done,
    input  logic                          host_rd,
    input  logic                          host_wr,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    output logic [DATA_W-1:0]             host_rdata,
    output logic                          irq
);
    logic [NUM_CH-1:0][STAT_W-1:0]     cause_all;
    logic [NUM_CH-1:0][RX_MASK_W-1:0]  rxm_all;
    logic [NUM_CH-1:0][TX_MASK_W-1:0]  txm_all;
    logic [NUM_CH-1:0][MAC_MASK_W-1:0] macm_all;
    logic [NUM_CH-1:0][NIB_W-1:0]      nib_all;
    logic [NUM_CH*NIB_W-1:0]           glob_w;
    logic [NUM_CH-1:0] clr_all, wr_rxm, wr_txm, wr_macm;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^host_wdata[DATA_W-1:MAC_MASK_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_ev_t ev_c;
        assign ev_c.mac_err = ev_mac_err[c*NUM_MAC_ERR +: NUM_MAC_ERR];
        assign ev_c.dma_err = ev_dma_err[c*NUM_DMA_ERR +: NUM_DMA_ERR];
        assign ev_c.cnt_inc = ev_cnt_inc[c*NUM_CNT +: NUM_CNT];
        assign ev_c.tx_done = ev_tx_done[c];
        assign ev_c.rx_done = ev_rx_done[c];

        evt_chan_cause #(.CNT_W(CNT_W)) u_cause (
            .clk     (clk),
            .rst     (rst),
            .ev      (ev_c),
            .clr     (clr_all[c]),
            .wr_rxm  (wr_rxm[c]),
            .wr_txm  (wr_txm[c]),
            .wr_macm (wr_macm[c]),
            .wdata   (host_wdata[MAC_MASK_W-1:0]),
            .cause   (cause_all[c]),
            .rxm     (rxm_all[c]),
            .txm     (txm_all[c]),
            .macm    (macm_all[c]),
            .nib     (nib_all[c])
        );
    end

    // channel c lands at bits [4c+3:4c]
    assign glob_w = nib_all;
    assign irq    = |glob_w;

    evt_host_port #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) u_host (
        .clk        (clk),
        .rst        (rst),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .cause_all  (cause_all),
        .rxm_all    (rxm_all),
        .txm_all    (txm_all),
        .macm_all   (macm_all),
        .glob       (glob_w),
        .host_rdata (host_rdata),
        .clr_all    (clr_all),
        .wr_rxm     (wr_rxm),
        .wr_txm     (wr_txm),
        .wr_macm    (wr_macm)
    );
endmodule

// File: rtl/chan_irq_aggregator_chk.sv
module chan_irq_aggregator_chk
    import evt_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          irq,
    input logic                          host_rd,
    input logic [DATA_W-1:0]             host_rdata,
    input logic [NUM_CH*NUM_MAC_ERR-1:0] ev_mac_err,
    input logic [NUM_CH*NUM_DMA_ERR-1:0] ev_dma_err,
    input logic [NUM_CH*NUM_CNT-1:0]     ev_cnt_inc,
    input logic [NUM_CH-1:0]             ev_tx_done,
    input logic [NUM_CH-1:0]             ev_rx_done,
    input logic [NUM_CH-1:0][STAT_W-1:0] cause_all,
    input logic [NUM_CH-1:0]             clr_all
);
    // R1: one cycle after reset, outputs are quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq && host_rdata == '0));

    // R8: no latched cause anywhere means no interrupt
    a_r8_irq_needs_cause: assert property (@(posedge clk) disable iff (rst)
        (cause_all == '0) |-> !irq);

    // R10: read data only follows a read strobe
    a_r10_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> (host_rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic any_ev;
        assign any_ev = (|ev_mac_err[c*NUM_MAC_ERR +: NUM_MAC_ERR]) ||
                        (|ev_dma_err[c*NUM_DMA_ERR +: NUM_DMA_ERR]) ||
                        (|ev_cnt_inc[c*NUM_CNT +: NUM_CNT]) ||
                        ev_tx_done[c] || ev_rx_done[c];

        // R2: a transmit-done pulse is latched at bit 15
        a_r2_txd_capture: assert property (@(posedge clk) disable iff (rst)
            ev_tx_done[c] |=> cause_all[c][TXD_BIT]);

        // R2: MAC error 0 is latched at bit 0
        a_r2_mac0_capture: assert property (@(posedge clk) disable iff (rst)
            ev_mac_err[c*NUM_MAC_ERR] |=> cause_all[c][0]);

        // R3: without a clearing read, set bits persist
        a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
            !clr_all[c] |=> ((cause_all[c] & $past(cause_all[c])) == $past(cause_all[c])));

        // R3: a clearing read with no new event empties the register
        a_r3_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_all[c] && !any_ev) |=> (cause_all[c] == '0));
    end
endmodule

bind chan_irq_aggregator chan_irq_aggregator_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .ev_mac_err (ev_mac_err),
    .ev_dma_err (ev_dma_err),
    .ev_cnt_inc (ev_cnt_inc),
    .ev_tx_done (ev_tx_done),
    .ev_rx_done (ev_rx_done),
    .cause_all  (cause_all),
    .clr_all    (clr_all)
);

// File: tb/chan_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module chan_irq_aggregator_tb_top;
    localparam int A_GLOB = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] ev_mac_err = '0;
    logic [11:0] ev_dma_err = '0;
    logic [19:0] ev_cnt_inc = '0;
    logic [3:0]  ev_tx_done = '0;
    logic [3:0]  ev_rx_done = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chan_irq_aggregator dut_i (
        .clk(clk), .rst(rst),
        .ev_mac_err(ev_mac_err), .ev_dma_err(ev_dma_err), .ev_cnt_inc(ev_cnt_inc),
        .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    function automatic int ra(int ch, int off);
        return ch * 4 + off;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 5'(a);
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'(a); host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse_mac(input int ch, input int b);
        @(negedge clk); ev_mac_err[ch*7+b] = 1'b1;
        @(negedge clk); ev_mac_err[ch*7+b] = 1'b0;
    endtask

    task automatic pulse_dma(input int ch, input int b);
        @(negedge clk); ev_dma_err[ch*3+b] = 1'b1;
        @(negedge clk); ev_dma_err[ch*3+b] = 1'b0;
    endtask

    task automatic hold_cnt(input int ch, input int idx, input int n);
        @(negedge clk); ev_cnt_inc[ch*5+idx] = 1'b1;
        repeat (n) @(negedge clk);
        ev_cnt_inc[ch*5+idx] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R10 idle rdata", host_rdata, 32'h0);
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 4; o++) begin
                rd(ra(c, o), d);
                chk("R1 register reset value", d, 32'h0);
            end
        rd(A_GLOB, d);
        chk("R1 global reset value", d, 32'h0);
    endtask

    task automatic t_error_bits();
        logic [31:0] d;
        for (int k = 0; k < 10; k++) begin
            if (k < 7) pulse_mac(1, k); else pulse_dma(1, k - 7);
            chk("R8 irq raised by error", {31'b0, irq}, 32'h1);
            rd(A_GLOB, d);
            chk("R7 error nibble of channel 1", d, 32'h10);
            rd(ra(1, 0), d);
            chk("R2 error cause bit", d, 32'h1 << k);
            rd(ra(1, 0), d);
            chk("R3 cleared after read", d, 32'h0);
            chk("R8 irq low after clear", {31'b0, irq}, 32'h0);
        end
    endtask

    task automatic t_done_bits();
        logic [31:0] d;
        @(negedge clk); ev_tx_done[2] = 1'b1;
        @(negedge clk); ev_tx_done[2] = 1'b0;
        rd(A_GLOB, d);
        chk("R7 tx-done nibble bit of channel 2", d, 32'h200);
        rd(ra(2, 0), d);
        chk("R2 tx-done cause bit 15", d, 32'h8000);
        @(negedge clk); ev_rx_done[3] = 1'b1;
        @(negedge clk); ev_rx_done[3] = 1'b0;
        rd(A_GLOB, d);
        chk("R7 rx-done nibble bit of channel 3", d, 32'h4000);
        rd(ra(3, 0), d);
        chk("R2 rx-done cause bit 16", d, 32'h10000);
    endtask

    task automatic t_read_race();
        logic [31:0] d;
        pulse_mac(0, 3);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 5'(ra(0, 0)); ev_tx_done[0] = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; ev_tx_done[0] = 1'b0;
        chk("R3 read returns pre-clear contents", host_rdata, 32'h8);
        chk("R3 same-cycle event keeps irq", {31'b0, irq}, 32'h1);
        rd(ra(0, 0), d);
        chk("R3 same-cycle event retained", d, 32'h8000);
        @(negedge clk);
        chk("R10 rdata zero without read", host_rdata, 32'h0);
    endtask

    task automatic t_counters();
        logic [31:0] d;
        hold_cnt(2, 3, 255);
        chk("R4 no overflow after 255", {31'b0, irq}, 32'h0);
        rd(ra(2, 0), d);
        chk("R4 cause clear after 255", d, 32'h0);
        hold_cnt(2, 3, 1);
        rd(A_GLOB, d);
        chk("R7 overflow nibble bit of channel 2", d, 32'h800);
        rd(ra(2, 0), d);
        chk("R4 overflow at 256th", d, 32'h2000);
        hold_cnt(2, 3, 255);
        rd(ra(2, 0), d);
        chk("R4 counter restarted from zero", d, 32'h0);
        hold_cnt(2, 3, 1);
        rd(ra(2, 0), d);
        chk("R4 second overflow at 512th", d, 32'h2000);
    endtask

    task automatic t_masks();
        logic [31:0] d;
        wr(ra(1, 2), 32'hF);
        rd(ra(1, 2), d);
        chk("R5 tx mask readback", d, 32'hF);
        @(negedge clk); ev_tx_done[1] = 1'b1;
        @(negedge clk); ev_tx_done[1] = 1'b0;
        chk("R5 masked cause keeps irq low", {31'b0, irq}, 32'h0);
        rd(A_GLOB, d);
        chk("R5 masked cause absent from nibble", d, 32'h0);
        rd(ra(1, 0), d);
        chk("R5 masked cause still latched", d, 32'h8000);
        wr(ra(1, 1), 32'hFFFF_FFFF);
        rd(ra(1, 1), d);
        chk("R9 rx mask field width", d, 32'h1);
        wr(ra(1, 3), 32'hFFFF_FFFF);
        rd(ra(1, 3), d);
        chk("R9 mac mask field width", d, 32'hFFF);
        wr(ra(1, 1), 32'h0); wr(ra(1, 2), 32'h0); wr(ra(1, 3), 32'h0);
        rd(ra(1, 3), d);
        chk("R5 mask cleared", d, 32'h0);
    endtask

    task automatic t_coll_mask();
        logic [31:0] d;
        wr(ra(0, 3), 32'h80);
        hold_cnt(0, 0, 256);
        chk("R6 masked collision overflow no irq", {31'b0, irq}, 32'h0);
        hold_cnt(0, 3, 256);
        chk("R6 FCS overflow still raises irq", {31'b0, irq}, 32'h1);
        rd(A_GLOB, d);
        chk("R6 overflow nibble from FCS only", d, 32'h8);
        rd(ra(0, 0), d);
        chk("R6 both overflows latched", d, 32'h2400);
        wr(ra(0, 3), 32'h0);
    endtask

    task automatic t_ignored_writes();
        logic [31:0] d;
        pulse_mac(3, 0);
        wr(ra(3, 0), 32'h0);
        rd(A_GLOB, d);
        chk("R9 write to cause address ignored", d, 32'h1000);
        wr(A_GLOB, 32'h0);
        rd(A_GLOB, d);
        chk("R9 write to global address ignored", d, 32'h1000);
        wr(ra(3, 0), 32'hFFFF_FFFF);
        for (int o = 1; o < 4; o++) begin
            rd(ra(3, o), d);
            chk("R9 cause-address write leaves masks", d, 32'h0);
        end
        rd(ra(3, 0), d);
        chk("R9 cause content after writes", d, 32'h1);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        @(negedge clk); ev_tx_done[0] = 1'b1; ev_rx_done[3] = 1'b1;
        @(negedge clk); ev_tx_done[0] = 1'b0; ev_rx_done[3] = 1'b0;
        rd(A_GLOB, d);
        chk("R7 two channels in global", d, 32'h4002);
        rd(ra(0, 0), d);
        chk("R8 irq held by other channel", {31'b0, irq}, 32'h1);
        rd(ra(3, 0), d);
        chk("R8 irq low when all served", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_error_bits();
        t_done_bits();
        t_read_race();
        t_counters();
        t_masks();
        t_coll_mask();
        t_ignored_writes();
        t_multi();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule